// File: doc/BRIEF.md
# External Interrupt Line Controller with Grouped Summary Outputs

This block watches 28 external interrupt inputs and turns each one into a sticky pending flag. The event that sets a flag can be a low level, a high level, a falling edge, a rising edge or either edge. Adjacent lines share one trigger setting, so line 2k and line 2k+1 always use the same trigger type. Each input passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one clock earlier.

Software sees the block through a plain 32-bit register port with four word addresses. It sets the trigger types, sets a per-line mask and acknowledges lines by writing ones to the pending register. The block drives four summary interrupt outputs to a downstream interrupt controller. Each output covers a fixed, uneven slice of the lines. An output is high while any line in its slice is both pending and unmasked. Software then reads the pending and mask registers to find out which lines are active.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is held and at its release, the mask register (address 0) reads 0x0FFFFFFF, the pending register (address 1) reads 0, both trigger registers (addresses 2 and 3) read 0 and all four summary outputs are low.
- R2: Register bits that would belong to lines above 27 ignore writes and read as 0. The mask and pending registers keep bits 31..28 at 0. The upper trigger register keeps only bits 22..20, 18..16, 14..12, 10..8, 6..4 and 2..0. The lower trigger register keeps bits 4p+2..4p for p = 0..7.
- R3: The trigger field for line n is a 3-bit field at bit (m/2)*4. For n < 16 it lives in address 2 with m = n. For n ≥ 16 it lives in address 3 with m = n−16. Both lines of a pair obey the same field.
- R4: A mask bit of 1 keeps that line from every summary output. The line's pending bit is still recorded and can still be read. A mask bit of 0 lets the line through.
- R5: A write to address 1 clears every pending bit written as 1. Pending bits written as 0 keep their value.
- R6: Trigger code 000 (low level) marks a line pending while its synchronized input is 0.
- R7: Trigger code 001 (high level) marks a line pending while its synchronized input is 1.
- R8: Trigger codes 010 and 011 (falling edge) mark a line pending when its synchronized input changes from 1 to 0.
- R9: Trigger codes 100 and 101 (rising edge) mark a line pending when its synchronized input changes from 0 to 1.
- R10: Trigger codes 110 and 111 (both edges) mark a line pending on any change of its synchronized input.
- R11: Summary output bit 0 covers lines 0–3, bit 1 covers lines 4–11, bit 2 covers lines 12–19 and bit 3 covers lines 20–27.
- R12: A level-triggered line is set pending again on every cycle its level condition holds. An acknowledge therefore takes effect only once the input is inactive.
- R13: If a trigger event and an acknowledge of the same line fall in the same cycle, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 28 | Raw external interrupt inputs, one per line |
| busWrEn | input | 1 | Write strobe for the register port |
| busAddr | input | 2 | Word address: 0 mask, 1 pending, 2 lower trigger, 3 upper trigger |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| sumIrq | output | 4 | Grouped summary interrupts |

## Verification
A wrong pending or mask bit shows up on the read port in the cycle after the register update. The summary outputs show it in the same cycle, because they are plain gating of register state. A wrong trigger decode or a wrong synchronizer depth shows as a pending bit that is missing, extra or set one cycle off. An input change has to appear in the pending register after the third rising clock edge. Grouping errors show as the wrong summary bit when a single line at either end of a slice is raised.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_LINES    = 28;
  localparam int LO_SPAN      = 16;
  localparam int FIELD_W      = 3;
  localparam int FIELD_STRIDE = 4;
  localparam int NUM_GROUPS   = 4;
  localparam int BUS_W        = 32;
  localparam int ADDR_W       = 2;
  localparam int SYNC_STAGES  = 2;

  localparam int GRP_FIRST [NUM_GROUPS] = '{0, 4, 12, 20};
  localparam int GRP_LAST  [NUM_GROUPS] = '{3, 11, 19, 27};

  localparam logic [ADDR_W-1:0] A_MASK  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PEND  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CFGLO = 2'd2;
  localparam logic [ADDR_W-1:0] A_CFGHI = 2'd3;

  typedef struct packed {
    logic wrMask;
    logic wrPendAck;
    logic wrCfgLo;
    logic wrCfgHi;
  } regStrobe_t;

  // Bits of a trigger register that hold a real field for nLines lines.
  function automatic logic [BUS_W-1:0] cfgKeep(input int nLines);
    logic [BUS_W-1:0] v;
    v = '0;
    for (int p = 0; p < (nLines + 1) / 2; p++) begin
      for (int b = 0; b < FIELD_W; b++) v[p*FIELD_STRIDE + b] = 1'b1;
    end
    return v;
  endfunction

  localparam logic [BUS_W-1:0] CFG_LO_KEEP = cfgKeep(LO_SPAN);
  localparam logic [BUS_W-1:0] CFG_HI_KEEP = cfgKeep(NUM_LINES - LO_SPAN);
endpackage

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rawIn,
  input  logic [FIELD_W-1:0] trigCode,
  output logic               hit
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;
  logic              cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], rawIn};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign cur = syncQ[STAGES-1];

  always_comb begin
    unique case (trigCode[2:1])
      2'b00:   hit = trigCode[0] ? cur : ~cur;
      2'b01:   hit = prevQ & ~cur;
      2'b10:   hit = ~prevQ & cur;
      default: hit = prevQ ^ cur;
    endcase
  end
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irqIn,
  input  regStrobe_t            stb,
  input  logic [BUS_W-1:0]      wdata,
  output logic [NUM_LINES-1:0]  maskQ,
  output logic [NUM_LINES-1:0]  pendQ,
  output logic [BUS_W-1:0]      cfgLoQ,
  output logic [BUS_W-1:0]      cfgHiQ,
  output logic [NUM_GROUPS-1:0] sumIrq
);
  logic [NUM_LINES-1:0] hitVec;
  logic [NUM_LINES-1:0] ackVec;
  logic [NUM_LINES-1:0] active;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam bit IS_LO = (n < LO_SPAN);
    localparam int POS   = IS_LO ? (n / 2) * FIELD_STRIDE
                                 : ((n - LO_SPAN) / 2) * FIELD_STRIDE;
    logic [FIELD_W-1:0] code;
    if (IS_LO) begin : g_lo
      assign code = cfgLoQ[POS +: FIELD_W];
    end else begin : g_hi
      assign code = cfgHiQ[POS +: FIELD_W];
    end
    ext_irq_line #(.STAGES(SYNC_STAGES)) line_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rawIn   (irqIn[n]),
      .trigCode(code),
      .hit     (hitVec[n])
    );
  end

  assign ackVec = stb.wrPendAck ? wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskQ  <= '1;
      pendQ  <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
    end else begin
      pendQ <= (pendQ & ~ackVec) | hitVec;
      if (stb.wrMask)  maskQ  <= wdata[NUM_LINES-1:0];
      if (stb.wrCfgLo) cfgLoQ <= wdata & CFG_LO_KEEP;
      if (stb.wrCfgHi) cfgHiQ <= wdata & CFG_HI_KEEP;
    end
  end

  assign active = pendQ & ~maskQ;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = GRP_FIRST[g];
    localparam int HI = GRP_LAST[g];
    assign sumIrq[g] = |active[HI:LO];
  end
endmodule

// File: rtl/ext_irq_busctl.sv
module ext_irq_busctl
  import ext_irq_pkg::*;
(
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_LINES-1:0] maskQ,
  input  logic [NUM_LINES-1:0] pendQ,
  input  logic [BUS_W-1:0]     cfgLoQ,
  input  logic [BUS_W-1:0]     cfgHiQ,
  output regStrobe_t           stb,
  output logic [BUS_W-1:0]     busRdData
);
  localparam int PAD = BUS_W - NUM_LINES;

  always_comb begin
    stb.wrMask    = busWrEn && (busAddr == A_MASK);
    stb.wrPendAck = busWrEn && (busAddr == A_PEND);
    stb.wrCfgLo   = busWrEn && (busAddr == A_CFGLO);
    stb.wrCfgHi   = busWrEn && (busAddr == A_CFGHI);
  end

  always_comb begin
    unique case (busAddr)
      A_MASK:  busRdData = {{PAD{1'b0}}, maskQ};
      A_PEND:  busRdData = {{PAD{1'b0}}, pendQ};
      A_CFGLO: busRdData = cfgLoQ;
      default: busRdData = cfgHiQ;
    endcase
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irqIn,
  input  logic                  busWrEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [BUS_W-1:0]      busWrData,
  output logic [BUS_W-1:0]      busRdData,
  output logic [NUM_GROUPS-1:0] sumIrq
);
  regStrobe_t           stb;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [BUS_W-1:0]     cfgLoQ;
  logic [BUS_W-1:0]     cfgHiQ;

  ext_irq_busctl ctl_i (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .maskQ    (maskQ),
    .pendQ    (pendQ),
    .cfgLoQ   (cfgLoQ),
    .cfgHiQ   (cfgHiQ),
    .stb      (stb),
    .busRdData(busRdData)
  );

  ext_irq_datapath dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .irqIn (irqIn),
    .stb   (stb),
    .wdata (busWrData),
    .maskQ (maskQ),
    .pendQ (pendQ),
    .cfgLoQ(cfgLoQ),
    .cfgHiQ(cfgHiQ),
    .sumIrq(sumIrq)
  );
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busWrEn,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [BUS_W-1:0]      busWrData,
  input logic [BUS_W-1:0]      busRdData,
  input logic [NUM_LINES-1:0]  maskQ,
  input logic [NUM_LINES-1:0]  pendQ,
  input logic [NUM_GROUPS-1:0] sumIrq
);
  logic [BUS_W-1:0] ackSeen;
  logic [BUS_W-1:0] pendWide;

  always_comb begin
    ackSeen  = (busWrEn && busAddr == A_PEND) ? busWrData : '0;
    pendWide = {{(BUS_W-NUM_LINES){1'b0}}, pendQ};
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (maskQ == '1 && pendQ == '0 && sumIrq == '0));

  // R2
  upper_lines_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == A_MASK || busAddr == A_PEND) |-> ((busRdData >> NUM_LINES) == '0));

  // R2
  cfg_hi_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == A_CFGHI) |-> ((busRdData & ~CFG_HI_KEEP) == '0));

  // R4
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&maskQ) |-> (sumIrq == '0));

  // R4
  summary_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sumIrq != '0) |-> ((pendQ & ~maskQ) != '0));

  // R5
  w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pendWide) & ~$past(ackSeen)) & ~pendWide) == '0));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .maskQ    (maskQ),
  .pendQ    (pendQ),
  .sumIrq   (sumIrq)
);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  import ext_irq_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NUM_LINES-1:0]  irqIn = '0;
  logic                  busWrEn = 1'b0;
  logic [ADDR_W-1:0]     busAddr = '0;
  logic [BUS_W-1:0]      busWrData = '0;
  logic [BUS_W-1:0]      busRdData;
  logic [NUM_GROUPS-1:0] sumIrq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irqIn    (irqIn),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .sumIrq   (sumIrq)
  );

  typedef struct {
    bit               isSum;
    logic [BUS_W-1:0] exp;
    string            tag;
  } expItem_t;

  expItem_t expQ[$];

  // Monitor: pops one expectation per cycle and compares at the falling edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      logic [BUS_W-1:0] got;
      it  = expQ.pop_front();
      got = it.isSum ? {{(BUS_W-NUM_GROUPS){1'b0}}, sumIrq} : busRdData;
      nChecks++;
      if (got !== it.exp) begin
        nFail++;
        $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expReg(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] e, input string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    busAddr = a;
    it.isSum = 1'b0;
    it.exp = e;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic expSum(input logic [NUM_GROUPS-1:0] e, input string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    it.isSum = 1'b1;
    it.exp = {{(BUS_W-NUM_GROUPS){1'b0}}, e};
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    @(posedge clk);
    #1;
    busWrEn = 1'b1;
    busAddr = a;
    busWrData = d;
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
  endtask

  task automatic setLine(input int idx, input logic v);
    irqIn[idx] = v;
    tick(4);
  endtask

  initial begin
    tick(2);
    // R1: values while reset is held
    expReg(A_MASK, 32'h0FFF_FFFF, "R1 mask at reset");
    expReg(A_PEND, 32'h0, "R1 pending at reset");
    expReg(A_CFGLO, 32'h0, "R1 cfgLo at reset");
    expReg(A_CFGHI, 32'h0, "R1 cfgHi at reset");
    expSum(4'h0, "R1 summary at reset");
    tick(1);
    rst_n = 1'b1;
    tick(4);
    // R6: all fields are low level, all inputs low
    expReg(A_PEND, 32'h0FFF_FFFF, "R6 low level sets all");
    expSum(4'h0, "R4 all masked");
    wr(A_CFGLO, 32'h4444_4444);
    wr(A_CFGHI, 32'h0044_4444);
    tick(4);
    wr(A_PEND, 32'h0FFF_FFFF);
    expReg(A_PEND, 32'h0, "R5 ack all");
    // R9 rising on line 5
    setLine(5, 1'b1);
    expReg(A_PEND, 32'h20, "R9 rising line5");
    expSum(4'h0, "R4 masked line5");
    wr(A_MASK, 32'h0);
    expSum(4'b0010, "R11 line5 in group1");
    // R5 write-one-to-clear
    wr(A_PEND, 32'h0);
    expReg(A_PEND, 32'h20, "R5 zero write keeps");
    wr(A_PEND, 32'h10);
    expReg(A_PEND, 32'h20, "R5 other bit keeps");
    wr(A_PEND, 32'h20);
    expReg(A_PEND, 32'h0, "R5 ack clears");
    expSum(4'h0, "R5 summary after ack");
    // R3 / R8: pair 4,5 to falling
    wr(A_CFGLO, 32'h4444_4244);
    expReg(A_CFGLO, 32'h4444_4244, "R3 cfgLo readback");
    setLine(5, 1'b0);
    expReg(A_PEND, 32'h20, "R8 falling line5");
    setLine(4, 1'b1);
    expReg(A_PEND, 32'h20, "R3 line4 shares falling");
    setLine(4, 1'b0);
    expReg(A_PEND, 32'h30, "R3 line4 falls");
    wr(A_PEND, 32'h30);
    // R7 / R12: high level on line 27
    wr(A_CFGHI, 32'h0014_4444);
    expReg(A_CFGHI, 32'h0014_4444, "R3 cfgHi readback");
    setLine(27, 1'b1);
    expReg(A_PEND, 32'h0800_0000, "R7 high level line27");
    expSum(4'b1000, "R11 line27 in group3");
    wr(A_PEND, 32'h0800_0000);
    expReg(A_PEND, 32'h0800_0000, "R12 level re-sets");
    setLine(27, 1'b0);
    wr(A_PEND, 32'h0800_0000);
    expReg(A_PEND, 32'h0, "R12 ack sticks once idle");
    // R6 low level on pair 12,13
    wr(A_CFGLO, 32'h4044_4244);
    tick(2);
    expReg(A_PEND, 32'h0000_3000, "R6 low level lines12,13");
    expSum(4'b0100, "R11 line12 in group2");
    irqIn[12] = 1'b1;
    setLine(13, 1'b1);
    wr(A_PEND, 32'h3000);
    expReg(A_PEND, 32'h0, "R12 cleared after release");
    // R10 both edges on pair 0,1
    wr(A_CFGLO, 32'h4044_4246);
    setLine(0, 1'b1);
    expReg(A_PEND, 32'h1, "R10 both edges rise");
    expSum(4'b0001, "R11 line0 in group0");
    wr(A_PEND, 32'h1);
    setLine(0, 1'b0);
    expReg(A_PEND, 32'h1, "R10 both edges fall");
    wr(A_PEND, 32'h1);
    // R13 event and ack in the same cycle
    setLine(0, 1'b1);
    wr(A_PEND, 32'h1);
    irqIn[0] = 1'b0;
    tick(1);
    wr(A_PEND, 32'h1);
    expReg(A_PEND, 32'h1, "R13 event wins over ack");
    wr(A_PEND, 32'h1);
    expReg(A_PEND, 32'h0, "R13 later ack clears");
    // R11 slice boundaries
    setLine(3, 1'b1);
    expSum(4'b0001, "R11 line3 in group0");
    wr(A_PEND, 32'h8);
    setLine(11, 1'b1);
    expSum(4'b0010, "R11 line11 in group1");
    wr(A_PEND, 32'h800);
    setLine(19, 1'b1);
    expSum(4'b0100, "R11 line19 in group2");
    wr(A_PEND, 32'h0008_0000);
    setLine(20, 1'b1);
    expSum(4'b1000, "R11 line20 in group3");
    // R4 partial mask
    wr(A_MASK, 32'h0010_0000);
    expSum(4'h0, "R4 masked line20");
    expReg(A_PEND, 32'h0010_0000, "R4 pending still recorded");
    wr(A_MASK, 32'h0);
    expSum(4'b1000, "R4 unmasked line20");
    wr(A_PEND, 32'h0010_0000);
    // R2 ignored bits
    wr(A_MASK, 32'hFFFF_FFFF);
    expReg(A_MASK, 32'h0FFF_FFFF, "R2 mask upper bits");
    wr(A_CFGHI, 32'hFFFF_FFFF);
    expReg(A_CFGHI, 32'h0077_7777, "R2 cfgHi unused fields");
    wr(A_CFGLO, 32'hFFFF_FFFF);
    expReg(A_CFGLO, 32'h7777_7777, "R2 cfgLo gaps");
    wr(A_PEND, 32'hF000_0000);
    expReg(A_PEND, 32'h0, "R2 pending upper bits");
    tick(2);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule